// File: doc/BRIEF.md
# Channel Event Interrupt Coalescer

This block gathers completion and error events that arrive from many channels and turns them into one level-sensitive interrupt line to the host, together with a first-in first-out list of the channel numbers that need attention. Each event carries a channel number and a kind code. A per-channel enable vector decides whether a channel takes part at all. A channel that already has an unread entry in the list is not added again. Its pending mark is cleared only when the host pops that entry.

Interrupts are coalesced. When the line rises, the block disarms itself. Later events only add list entries, and the line stays high until the host writes a re-arm strobe. After a re-arm, any entries still in the list raise the line again one cycle later, so an event that slipped in during servicing is never lost. When more channels need service than the list can hold, a sticky overflow flag tells the host to scan every channel.

Top module: `irq_notify_mgr`

## Requirements
- R1: After reset `irq` is 0 and `ovf_flag` is 0, and the list is empty.
- R2: An event on an enabled channel adds that channel to the list when its kind is 0 (transmit done), 1 (receive done) or 2 (error). Kind 3 is a null code and adds nothing.
- R3: Events on a channel whose `ch_enable` bit is 0 add no entry and raise no interrupt.
- R4: A channel that is already in the list is not entered twice. Once its entry has been popped, a new event enters it again.
- R5: A pop returns the oldest entry. The response appears on `pop_data` after the clock edge that samples `host_pop`, with bit CH_W as the valid bit and bits CH_W-1:0 as the channel number.
- R6: A pop on an empty list returns valid = 0 and leaves the list unchanged.
- R7: While armed, `irq` rises at the clock edge after the one at which the list first becomes non-empty.
- R8: Once high, `irq` stays high until a `host_rearm` strobe, even when the list has been drained. Events in the meantime only add entries.
- R9: `host_rearm` drops `irq` at the next edge. If the list is non-empty at that point, `irq` rises again at the following edge. If the list is empty, `irq` stays low until a new entry is written.
- R10: A new entry that finds the list full, with no pop in the same cycle, is dropped and sets the sticky `ovf_flag`. That channel is not marked pending. `host_rearm` clears `ovf_flag`, unless an overflow happens in the same cycle, in which case the flag is set.
- R11: When the host pops a channel's entry in the same cycle as a new event for that channel, the channel is entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_chan | input | CH_W | Channel number of the event |
| evt_kind | input | 2 | 0 transmit done, 1 receive done, 2 error, 3 null |
| ch_enable | input | NUM_CH | Per-channel interrupt enable |
| host_rearm | input | 1 | Host write that re-enables the interrupt and clears overflow |
| host_pop | input | 1 | Host read strobe of the list pop register |
| irq | output | 1 | Level interrupt to the host |
| ovf_flag | output | 1 | Sticky list overflow indication |
| pop_data | output | CH_W+1 | {valid, channel} returned by the last pop |

## Verification
The hardest cases to reach from the ports are coincidences. One is a pop that frees the head slot in the same cycle that an event arrives for that very channel. Another is a full list that is popped and written in the same cycle. A third is a re-arm that lands while entries are still waiting. Directed steps build each case on purpose, first by filling the list with distinct channels and then by issuing the pop, the event and the re-arm in the chosen cycle. A long random run then uses 16 channels against an 8-deep list with frequent re-arms, which produces many overflows and clearances. Every step is compared with a bench model of the list, the pending marks, the line and the flag.

// File: rtl/irq_notify_pkg.sv
// Shared definitions for the channel event interrupt coalescer.
// Assumes a 2-bit event kind code, where code 3 is a null event.
package irq_notify_pkg;

    typedef enum logic [1:0] {
        EVK_TX_DONE = 2'd0,
        EVK_RX_DONE = 2'd1,
        EVK_ERROR   = 2'd2,
        EVK_NULL    = 2'd3
    } evt_kind_e;

    // True for kinds that must be reported to the host
    function automatic logic kind_reports(input logic [1:0] kind);
        return kind != EVK_NULL;
    endfunction

endpackage

// File: rtl/irq_evt_filter.sv
// Event filter: screens incoming events by kind and channel enable, and
// suppresses duplicates through one pending bit per channel. It decides
// whether a channel is pushed into the list or whether the push overflows.
// Assumes evt_chan < NUM_CH and that pop_eff only pulses for a non-empty list.
module irq_evt_filter
    import irq_notify_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [CH_W-1:0]   evt_chan,
    input  logic [1:0]        evt_kind,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic              pop_eff,
    input  logic [CH_W-1:0]   pop_chan,
    input  logic              list_full,
    output logic              push,
    output logic [CH_W-1:0]   push_chan,
    output logic              ovf_hit,
    output logic [NUM_CH-1:0] pending
);

    logic [NUM_CH-1:0] pending_q;
    logic              hit, releasing, dup, fresh, room;

    // Classify the current event: accepted, duplicate, room in the list
    always_comb begin
        hit       = evt_valid && kind_reports(evt_kind) && ch_enable[evt_chan];
        releasing = pop_eff && (pop_chan == evt_chan);
        dup       = pending_q[evt_chan] && !releasing;
        fresh     = hit && !dup;
        room      = !list_full || pop_eff;
        push      = fresh && room;
        ovf_hit   = fresh && !room;
        push_chan = evt_chan;
    end

    // One pending bit per channel: set on push, cleared when popped
    for (genvar g = 0; g < NUM_CH; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n)
                pending_q[g] <= 1'b0;
            else if (push && push_chan == CH_W'(g))
                pending_q[g] <= 1'b1;
            else if (pop_eff && pop_chan == CH_W'(g))
                pending_q[g] <= 1'b0;
        end
    end

    assign pending = pending_q;

    // R3
    disabled_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !ch_enable[evt_chan]) |-> !push && !ovf_hit);

endmodule

// File: rtl/irq_chan_fifo.sv
// Notification list: a FIFO of channel numbers with a sticky overflow flag.
// Assumes push never arrives when full without a pop in the same cycle
// (the filter converts that case into ovf_set), and pop only when non-empty.
module irq_chan_fifo #(
    parameter int DEPTH = 8,
    parameter int CH_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [CH_W-1:0]            push_chan,
    input  logic                       pop,
    output logic [CH_W-1:0]            head_chan,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       ovf_set,
    input  logic                       ovf_clr,
    output logic                       ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CH_W-1:0]  mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (push)
            mem_q[wr_ptr_q] <= push_chan;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Sticky overflow: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (ovf_set)
            ovf_q <= 1'b1;
        else if (ovf_clr)
            ovf_q <= 1'b0;
    end

    assign head_chan = mem_q[rd_ptr_q];
    assign count     = cnt_q;
    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign ovf       = ovf_q;

    // R10
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R10
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_q) |-> $past(ovf_clr));

endmodule

// File: rtl/irq_line_ctrl.sv
// Interrupt line control: raises the line when armed and the list holds
// entries, then stays disarmed until the host re-arms. The line being
// high is the disarmed state. Assumes list_nonempty comes from a register.
module irq_line_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rearm,
    input  logic list_nonempty,
    output logic irq
);

    logic irq_q;

    // Raise on waiting entries, hold until re-arm
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (rearm)
            irq_q <= 1'b0;
        else if (list_nonempty)
            irq_q <= 1'b1;
    end

    assign irq = irq_q;

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> $past(rearm));

    // R9
    rearm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> !irq_q);

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rearm && list_nonempty) |=> irq_q);

endmodule

// File: rtl/irq_notify_mgr.sv
// Channel event interrupt coalescer, top level. Connects the event filter,
// the notification list and the interrupt line, and registers the response
// to host pop reads. Assumes the host strobes are single-cycle pulses.
module irq_notify_mgr
    import irq_notify_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int DEPTH  = 8,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [CH_W-1:0]   evt_chan,
    input  logic [1:0]        evt_kind,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic              host_rearm,
    input  logic              host_pop,
    output logic              irq,
    output logic              ovf_flag,
    output logic [CH_W:0]     pop_data
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              push, ovf_hit, empty, full, pop_eff;
    logic [CH_W-1:0]   push_chan, head_chan;
    logic [CNT_W-1:0]  count;
    logic [NUM_CH-1:0] pending;
    logic [CH_W:0]     pop_data_q;

    assign pop_eff = host_pop && !empty;

    irq_evt_filter #(.NUM_CH(NUM_CH), .CH_W(CH_W)) filt_i (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_chan(evt_chan), .evt_kind(evt_kind),
        .ch_enable(ch_enable), .pop_eff(pop_eff), .pop_chan(head_chan),
        .list_full(full), .push(push), .push_chan(push_chan),
        .ovf_hit(ovf_hit), .pending(pending)
    );

    irq_chan_fifo #(.DEPTH(DEPTH), .CH_W(CH_W)) list_i (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_chan(push_chan), .pop(pop_eff),
        .head_chan(head_chan), .empty(empty), .full(full), .count(count),
        .ovf_set(ovf_hit), .ovf_clr(host_rearm), .ovf(ovf_flag)
    );

    irq_line_ctrl line_i (
        .clk(clk), .rst_n(rst_n),
        .rearm(host_rearm), .list_nonempty(!empty), .irq(irq)
    );

    // Pop response register: {valid, channel}
    always_ff @(posedge clk) begin
        if (!rst_n)
            pop_data_q <= '0;
        else if (host_pop)
            pop_data_q <= {!empty, head_chan};
    end

    assign pop_data = pop_data_q;

    // R4
    pending_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pending) == int'(count));

    // R6
    empty_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && empty) |=> !pop_data[CH_W]);

endmodule

// File: tb/irq_notify_mgr_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared each cycle against a reference model held in bench variables.
module irq_notify_mgr_tb_top;

    localparam int NUM_CH = 16;
    localparam int DEPTH  = 8;
    localparam int CH_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              evt_valid;
    logic [CH_W-1:0]   evt_chan;
    logic [1:0]        evt_kind;
    logic [NUM_CH-1:0] ch_enable;
    logic              host_rearm, host_pop;
    logic              irq, ovf_flag;
    logic [CH_W:0]     pop_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    int  q[$];
    bit  pend[NUM_CH];
    bit  irq_m, ovf_m;
    bit  popv_m;
    int  popc_m;

    always #10 clk = ~clk;

    irq_notify_mgr #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_chan(evt_chan),
        .evt_kind(evt_kind), .ch_enable(ch_enable), .host_rearm(host_rearm),
        .host_pop(host_pop), .irq(irq), .ovf_flag(ovf_flag), .pop_data(pop_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Expected next interrupt level from the requirements (R7, R8, R9)
    function automatic bit exp_irq(input bit cur, input bit rearm, input int size);
        return rearm ? 1'b0 : (cur || size != 0);
    endfunction

    // One clock of stimulus, model update and comparison
    task automatic step(input bit ev, input int ch, input int kind,
                        input bit rearm, input bit pop, input string tag);
        int  old_size;
        bit  ov;
        @(negedge clk);
        evt_valid  = ev;
        evt_chan   = CH_W'(ch);
        evt_kind   = 2'(kind);
        host_rearm = rearm;
        host_pop   = pop;
        old_size   = q.size();
        ov         = 0;
        if (pop) begin
            if (old_size > 0) begin
                popv_m = 1; popc_m = q[0];
                pend[q[0]] = 0;
                void'(q.pop_front());
            end else begin
                popv_m = 0;
            end
        end
        if (ev && kind != 3 && ch_enable[ch] && !pend[ch]) begin
            if (q.size() < DEPTH) begin
                q.push_back(ch);
                pend[ch] = 1;
            end else begin
                ov = 1;
            end
        end
        irq_m = exp_irq(irq_m, rearm, old_size);
        ovf_m = ov ? 1'b1 : (rearm ? 1'b0 : ovf_m);
        @(posedge clk);
        #2;
        chk(irq == irq_m, tag, "irq", int'(irq), int'(irq_m));
        chk(ovf_flag == ovf_m, tag, "ovf_flag", int'(ovf_flag), int'(ovf_m));
        if (pop) begin
            chk(pop_data[CH_W] == popv_m, tag, "pop valid",
                int'(pop_data[CH_W]), int'(popv_m));
            if (popv_m)
                chk(int'(pop_data[CH_W-1:0]) == popc_m, tag, "pop chan",
                    int'(pop_data[CH_W-1:0]), popc_m);
        end
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; evt_valid = 0; evt_chan = '0; evt_kind = '0;
        ch_enable = '1; host_rearm = 0; host_pop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk(irq == 0, "R1", "irq", int'(irq), 0);
        chk(ovf_flag == 0, "R1", "ovf_flag", int'(ovf_flag), 0);
        // R6: empty pop
        step(0, 0, 0, 0, 1, "R6");
        // R2: null kind ignored, then pop shows nothing
        step(1, 3, 3, 0, 0, "R2");
        step(0, 0, 0, 0, 1, "R2");
        // R7: first entry raises line one edge later
        step(1, 2, 0, 0, 0, "R7");
        idle("R7");
        // R3: disabled channel
        ch_enable[5] = 1'b0;
        step(1, 5, 2, 0, 0, "R3");
        // R4: duplicate suppressed, R8 events while masked only add entries
        step(1, 2, 1, 0, 0, "R4");
        step(1, 6, 2, 0, 0, "R8");
        step(0, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 1, "R4");
        // R4: re-entry after pop
        step(1, 2, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 1, "R4");
        // R8: drained list keeps line high
        idle("R8");
        // R9: re-arm with empty list stays low
        step(0, 0, 0, 1, 0, "R9");
        idle("R9");
        ch_enable[5] = 1'b1;
        // R5: order
        step(1, 7, 0, 0, 0, "R5");
        step(1, 1, 1, 0, 0, "R5");
        step(1, 9, 2, 0, 0, "R5");
        step(0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 1, "R5");
        // R10: overflow
        for (int i = 0; i < DEPTH + 1; i++) step(1, i + 4, 0, 0, 0, "R10");
        // R10: full plus pop plus new event is no overflow; R11 head re-entry
        step(1, 4, 1, 0, 1, "R11");
        step(1, 15, 0, 0, 1, "R10");
        // R9: re-arm with waiting entries reasserts; clears overflow
        step(0, 0, 0, 1, 0, "R9");
        idle("R9");
        // Drain
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 1, 0, "R9");
        // Random phase
        for (int i = 0; i < 5000; i++) begin
            if ($urandom_range(0, 49) == 0)
                ch_enable[$urandom_range(0, NUM_CH - 1)] ^= 1'b1;
            step($urandom_range(0, 1) == 1, $urandom_range(0, NUM_CH - 1),
                 $urandom_range(0, 3), $urandom_range(0, 9) == 0,
                 $urandom_range(0, 2) == 0, "R2 R4 R5 R8 R9 R10 R11 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule